// File: doc/BRIEF.md
# SRAM Bus Cycle Sequencer

This block turns one internal memory request into one timed external bus cycle for an SRAM-style device sitting in a single memory area. A request carries an address, a read/write flag, per-byte lane enables, write data and, for burst reads, a beat count. The block compares three upper address bits with a programmed area code. If they match, it runs a cycle whose phases can each be set separately: address setup, chip-select-to-strobe delay, strobe with wait states, strobe-to-chip-select negate delay, and address hold. If they do not match, it acknowledges the request without touching the bus.

The external side has an active-low chip select, an active-low read strobe that doubles as output enable, active-low per-lane write strobes, an active-low bus-start marker, and an active-low ready input. Ready can stretch a strobe only when wait states are programmed. An optional burst-ROM mode keeps the read strobe asserted across several beats and gives every beat after the first its own programmable pitch. The configuration is captured when a request is accepted, so the cycle in progress keeps its timing even if the configuration inputs change.

Top module: `sram_cycle_seq`

## Requirements
- R1: A request is a hit when `req_addr[28:26]` equals `cfg_area`. Only a hit asserts `ext_cs_n`. A miss gives `done` in the first cycle after acceptance and asserts no strobe.
- R2: Counting the cycle after the acceptance edge as cycle 1, `ext_cs_n` first goes low in cycle `cfg_setup`+1.
- R3: The strobe starts `cfg_rd_dly` cycles after chip select on a read and `cfg_wr_dly` cycles after it on a write. Strobes are only active while chip select is low.
- R4: A single-beat strobe lasts 1 + W cycles, where W is `cfg_wait`, and any value above 25 counts as 25.
- R5: When W > 0, `ext_rdy_n` is sampled at each rising edge from the last wait cycle on. Each sample that finds it high adds one strobe cycle. Ready can never shorten the strobe below 1 + W cycles.
- R6: When W = 0, the strobe lasts exactly one cycle whatever `ext_rdy_n` does.
- R7: After the strobe ends, `ext_cs_n` stays low for `cfg_neg_dly` more cycles.
- R8: After chip select rises, `ext_addr` holds the request address for `cfg_hold` cycles. `done` then pulses for exactly one cycle, and `busy` is low in the following cycle.
- R9: `ext_bs_n` goes low in the first cycle of chip select. It stays low for 2 cycles when `cfg_bs_long` is 1 and the relevant strobe delay (read or write) is nonzero. Otherwise it stays low for 1 cycle.
- R10: On a write, `ext_we_n[i]` goes low during the strobe only when `req_be[i]` is 1, `ext_wdata` carries the write data, and `ext_rd_n` stays high. On a read, `ext_rd_n` goes low during the strobe and all of `ext_we_n` stay high.
- R11: On a read, `ext_rdata` is captured at the edge that ends each beat's strobe. It appears on `rdata` with a one-cycle `rdata_valid` pulse. A write produces no `rdata_valid`.
- R12: With `cfg_burst` = 1, a read runs `req_beats`+1 beats with `ext_rd_n` held low throughout. Every beat after the first lasts 1 + `cfg_pitch` cycles, and `ext_addr` advances by 8 bytes per beat. A write ignores the burst setting and runs a single beat.
- R13: The configuration inputs are captured at acceptance. Changing them during a cycle does not alter that cycle.
- R14: While `busy` is high, requests are ignored. While idle, `ext_cs_n`, `ext_rd_n`, `ext_bs_n` and all `ext_we_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 8 | Byte lane enables for writes |
| req_wdata | input | 64 | Write data |
| req_beats | input | 3 | Burst beats minus one |
| cfg_area | input | 3 | Area code matched to address bits 28:26 |
| cfg_setup | input | 3 | Address setup cycles before chip select |
| cfg_rd_dly | input | 3 | Chip-select-to-strobe delay for reads |
| cfg_wr_dly | input | 3 | Chip-select-to-strobe delay for writes |
| cfg_wait | input | 5 | Wait states, 0 to 25 |
| cfg_neg_dly | input | 3 | Strobe-to-chip-select negate delay |
| cfg_hold | input | 3 | Address hold cycles after chip select |
| cfg_bs_long | input | 1 | Request 2-cycle bus-start marker |
| cfg_burst | input | 1 | Burst-ROM read mode |
| cfg_pitch | input | 3 | Wait cycles for burst beats after the first |
| ext_rdy_n | input | 1 | External ready, active low |
| ext_rdata | input | 64 | External read data |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 64 | Captured read data |
| rdata_valid | output | 1 | Pulse per captured beat |
| ext_addr | output | 32 | External address |
| ext_wdata | output | 64 | External write data |
| ext_cs_n | output | 1 | Chip select, active low |
| ext_rd_n | output | 1 | Read strobe / output enable, active low |
| ext_we_n | output | 8 | Per-lane write strobes, active low |
| ext_bs_n | output | 1 | Bus-start marker, active low |

## Verification
The assertions take for granted that `req_valid` is only raised together with stable request fields, and that the configuration inputs hold a legal value at the edge where a request is accepted. They make no assumption about `ext_rdy_n`: it may toggle freely, because the properties only tie strobe exit to the latched wait count. The stimulus changes every input on the falling edge, and raises `req_valid` only after programming the configuration. It drives ready from its own count of strobe cycles, and changes the configuration or raises a second request mid-cycle only in the two scenarios built to show those inputs have no effect.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  localparam int CNT_W = 5;
  localparam logic [CNT_W-1:0] WAIT_MAX = 5'd25;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_DLY, PH_STRB, PH_NEG, PH_HOLD, PH_DONE
  } phase_t;

  // Timing settings of one access; dly already holds the read or write delay.
  typedef struct packed {
    logic [2:0]       setup;
    logic [2:0]       dly;
    logic [CNT_W-1:0] wait_n;
    logic [2:0]       negd;
    logic [2:0]       hold;
    logic             bs2;
    logic             burst;
    logic [2:0]       pitch;
  } seq_cfg_t;

  function automatic logic [CNT_W-1:0] wait_eff(input logic [CNT_W-1:0] w);
    return (w > WAIT_MAX) ? WAIT_MAX : w;
  endfunction

  function automatic logic [1:0] bs_cycles(input logic bs2, input logic [2:0] dly);
    return (bs2 && dly != 3'd0) ? 2'd2 : 2'd1;
  endfunction

  function automatic logic cs_phase(input phase_t p);
    return (p == PH_DLY) || (p == PH_STRB) || (p == PH_NEG);
  endfunction

  // First phase of nonzero length from setup onward.
  function automatic phase_t enter_setup(input seq_cfg_t c);
    if (c.setup != 3'd0) return PH_SETUP;
    if (c.dly != 3'd0) return PH_DLY;
    return PH_STRB;
  endfunction

  // First phase of nonzero length after the strobe.
  function automatic phase_t enter_neg(input seq_cfg_t c);
    if (c.negd != 3'd0) return PH_NEG;
    if (c.hold != 3'd0) return PH_HOLD;
    return PH_DONE;
  endfunction

  // Counter load on entering a phase: remaining cycles minus one.
  function automatic logic [CNT_W-1:0] load_for(input phase_t p, input seq_cfg_t c);
    case (p)
      PH_SETUP: return {2'b00, c.setup} - 5'd1;
      PH_DLY:   return {2'b00, c.dly} - 5'd1;
      PH_STRB:  return wait_eff(c.wait_n);
      PH_NEG:   return {2'b00, c.negd} - 5'd1;
      PH_HOLD:  return {2'b00, c.hold} - 5'd1;
      default:  return '0;
    endcase
  endfunction

endpackage

// File: rtl/seq_area_match.sv
module seq_area_match #(
  parameter int AW  = 32,
  parameter int LSB = 26,
  parameter int W   = 3
) (
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  area,
  output logic          hit
);
  assign hit = (addr[LSB+W-1:LSB] == area);
endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
  import sram_seq_pkg::*;
#(
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hit,
  input  seq_cfg_t          cfg_live,
  input  logic              write_q,
  input  logic [BEAT_W-1:0] beats_m1,
  input  logic              rdy_n,
  output phase_t            ph,
  output logic [BEAT_W-1:0] beat,
  output logic              strb_last,
  output logic              strb_exit,
  output logic              wait_zero,
  output logic              bs_act
);
  phase_t            ph_q, ph_d;
  seq_cfg_t          cfg_q, c;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cur_wait_q;
  logic [1:0]        bs_q, bs_d;
  logic [BEAT_W-1:0] beat_q;
  logic              more_beats, reenter, changed;

  assign c          = (ph_q == PH_IDLE) ? cfg_live : cfg_q;
  assign strb_last  = (ph_q == PH_STRB) && (cnt_q == '0);
  assign wait_zero  = (cur_wait_q == '0);
  assign strb_exit  = strb_last && (wait_zero || !rdy_n);
  assign more_beats = cfg_q.burst && !write_q && (beat_q != beats_m1);
  assign reenter    = strb_exit && more_beats;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE:  if (start) ph_d = hit ? enter_setup(c) : PH_DONE;
      PH_SETUP: if (cnt_q == '0) ph_d = (c.dly != 3'd0) ? PH_DLY : PH_STRB;
      PH_DLY:   if (cnt_q == '0) ph_d = PH_STRB;
      PH_STRB:  if (strb_exit && !more_beats) ph_d = enter_neg(c);
      PH_NEG:   if (cnt_q == '0) ph_d = (c.hold != 3'd0) ? PH_HOLD : PH_DONE;
      PH_HOLD:  if (cnt_q == '0) ph_d = PH_DONE;
      PH_DONE:  ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
    changed = (ph_d != ph_q);
    if (reenter)           cnt_d = {2'b00, cfg_q.pitch};
    else if (changed)      cnt_d = load_for(ph_d, c);
    else if (cnt_q != '0)  cnt_d = cnt_q - 5'd1;
    else                   cnt_d = cnt_q;
    if (!cs_phase(ph_q) && cs_phase(ph_d)) bs_d = bs_cycles(c.bs2, c.dly);
    else if (bs_q != 2'd0)                 bs_d = bs_q - 2'd1;
    else                                   bs_d = bs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      cfg_q      <= '0;
      cnt_q      <= '0;
      cur_wait_q <= '0;
      bs_q       <= 2'd0;
      beat_q     <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      bs_q  <= bs_d;
      if (ph_q == PH_IDLE && start) begin
        cfg_q  <= cfg_live;
        beat_q <= '0;
      end else if (reenter) begin
        beat_q <= beat_q + 1'b1;
      end
      if (reenter || (changed && ph_d == PH_STRB)) cur_wait_q <= cnt_d;
    end
  end

  assign ph     = ph_q;
  assign beat   = beat_q;
  assign bs_act = (bs_q != 2'd0) && cs_phase(ph_q);
endmodule

// File: rtl/seq_strobe_drv.sv
module seq_strobe_drv
  import sram_seq_pkg::*;
#(
  parameter int NB = 8
) (
  input  phase_t        ph,
  input  logic          write_q,
  input  logic [NB-1:0] be_q,
  input  logic          bs_act,
  output logic          cs_n,
  output logic          rd_n,
  output logic [NB-1:0] we_n,
  output logic          bs_n
);
  logic strobe_on;
  assign strobe_on = (ph == PH_STRB);
  assign cs_n = !cs_phase(ph);
  assign rd_n = !(strobe_on && !write_q);
  assign bs_n = !bs_act;

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign we_n[i] = !(strobe_on && write_q && be_q[i]);
  end
endmodule

// File: rtl/sram_cycle_seq.sv
module sram_cycle_seq
  import sram_seq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 64,
  parameter int AREA_LSB = 26,
  parameter int AREA_W   = 3,
  parameter int BEAT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  input  logic [DW/8-1:0]   req_be,
  input  logic [DW-1:0]     req_wdata,
  input  logic [BEAT_W-1:0] req_beats,
  input  logic [AREA_W-1:0] cfg_area,
  input  logic [2:0]        cfg_setup,
  input  logic [2:0]        cfg_rd_dly,
  input  logic [2:0]        cfg_wr_dly,
  input  logic [4:0]        cfg_wait,
  input  logic [2:0]        cfg_neg_dly,
  input  logic [2:0]        cfg_hold,
  input  logic              cfg_bs_long,
  input  logic              cfg_burst,
  input  logic [2:0]        cfg_pitch,
  input  logic              ext_rdy_n,
  input  logic [DW-1:0]     ext_rdata,
  output logic              busy,
  output logic              done,
  output logic [DW-1:0]     rdata,
  output logic              rdata_valid,
  output logic [AW-1:0]     ext_addr,
  output logic [DW-1:0]     ext_wdata,
  output logic              ext_cs_n,
  output logic              ext_rd_n,
  output logic [DW/8-1:0]   ext_we_n,
  output logic              ext_bs_n
);
  localparam int NB       = DW / 8;
  localparam int LANE_SH  = $clog2(NB);

  // Named events for the checker.
  logic              hit, hit_q, start;
  logic              strb_last, strb_exit, wait_zero, bs_act, capture;
  phase_t            ph;
  logic [BEAT_W-1:0] beat;
  seq_cfg_t          cfg_live;

  logic [AW-1:0]     addr_q;
  logic              write_q;
  logic [NB-1:0]     be_q;
  logic [DW-1:0]     wdata_q;
  logic [BEAT_W-1:0] beats_q;

  assign start = req_valid && (ph == PH_IDLE);

  always_comb begin
    cfg_live.setup  = cfg_setup;
    cfg_live.dly    = req_write ? cfg_wr_dly : cfg_rd_dly;
    cfg_live.wait_n = cfg_wait;
    cfg_live.negd   = cfg_neg_dly;
    cfg_live.hold   = cfg_hold;
    cfg_live.bs2    = cfg_bs_long;
    cfg_live.burst  = cfg_burst;
    cfg_live.pitch  = cfg_pitch;
  end

  seq_area_match #(.AW(AW), .LSB(AREA_LSB), .W(AREA_W)) u_match (
    .addr (req_addr),
    .area (cfg_area),
    .hit  (hit)
  );

  seq_phase_fsm #(.BEAT_W(BEAT_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .hit       (hit),
    .cfg_live  (cfg_live),
    .write_q   (write_q),
    .beats_m1  (beats_q),
    .rdy_n     (ext_rdy_n),
    .ph        (ph),
    .beat      (beat),
    .strb_last (strb_last),
    .strb_exit (strb_exit),
    .wait_zero (wait_zero),
    .bs_act    (bs_act)
  );

  seq_strobe_drv #(.NB(NB)) u_drv (
    .ph      (ph),
    .write_q (write_q),
    .be_q    (be_q),
    .bs_act  (bs_act),
    .cs_n    (ext_cs_n),
    .rd_n    (ext_rd_n),
    .we_n    (ext_we_n),
    .bs_n    (ext_bs_n)
  );

  assign capture = strb_exit && !write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q      <= '0;
      write_q     <= 1'b0;
      be_q        <= '0;
      wdata_q     <= '0;
      beats_q     <= '0;
      hit_q       <= 1'b0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      if (start) begin
        addr_q  <= req_addr;
        write_q <= req_write;
        be_q    <= req_be;
        wdata_q <= req_wdata;
        beats_q <= req_beats;
        hit_q   <= hit;
      end
      rdata_valid <= capture;
      if (capture) rdata <= ext_rdata;
    end
  end

  assign ext_addr  = addr_q + ({{(AW-BEAT_W){1'b0}}, beat} << LANE_SH);
  assign ext_wdata = wdata_q;
  assign busy      = (ph != PH_IDLE);
  assign done      = (ph == PH_DONE);
endmodule

// File: rtl/sram_cycle_seq_chk.sv
module sram_cycle_seq_chk #(
  parameter int NB = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          rdata_valid,
  input logic          ext_cs_n,
  input logic          ext_rd_n,
  input logic [NB-1:0] ext_we_n,
  input logic          ext_bs_n,
  input logic          hit_q,
  input logic          strb_last,
  input logic          strb_exit,
  input logic          wait_zero
);
  p_cs_needs_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_cs_n |-> hit_q);

  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !(&ext_we_n)) |-> !ext_cs_n);

  p_rdy_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_last && wait_zero) |-> strb_exit);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_bs_in_cs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_bs_n |-> !ext_cs_n);

  p_rd_we_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !(&ext_we_n)));

  p_capture_on_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> $past(!ext_rd_n));

  p_idle_quiet_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ext_cs_n && ext_rd_n && (&ext_we_n) && ext_bs_n));
endmodule

bind sram_cycle_seq sram_cycle_seq_chk #(.NB(NB)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .rdata_valid (rdata_valid),
  .ext_cs_n    (ext_cs_n),
  .ext_rd_n    (ext_rd_n),
  .ext_we_n    (ext_we_n),
  .ext_bs_n    (ext_bs_n),
  .hit_q       (hit_q),
  .strb_last   (strb_last),
  .strb_exit   (strb_exit),
  .wait_zero   (wait_zero)
);

// File: tb/sram_cycle_seq_tb.sv
module sram_cycle_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_be = '0;
  logic [63:0] req_wdata = '0;
  logic [2:0]  req_beats = '0;
  logic [2:0]  cfg_area = 3'd3;
  logic [2:0]  cfg_setup = '0, cfg_rd_dly = '0, cfg_wr_dly = '0;
  logic [4:0]  cfg_wait = '0;
  logic [2:0]  cfg_neg_dly = '0, cfg_hold = '0, cfg_pitch = '0;
  logic        cfg_bs_long = 1'b0, cfg_burst = 1'b0;
  logic        ext_rdy_n = 1'b0;
  logic [63:0] ext_rdata;
  logic        busy, done, rdata_valid, ext_cs_n, ext_rd_n, ext_bs_n;
  logic [63:0] rdata, ext_wdata;
  logic [31:0] ext_addr;
  logic [7:0]  ext_we_n;

  int total = 0;
  int bad = 0;

  // Measurements of one access; cycle 1 is the first after acceptance.
  int m_first_cs, m_first_str, m_str, m_cs, m_bs, m_bs_first, m_rd, m_done, m_nv, m_hold_bad;
  logic [7:0]  m_we;
  logic [63:0] m_wd;
  logic [63:0] m_data [8];

  always #2 clk = ~clk;

  // Device model: data is a function of the address it sees.
  assign ext_rdata = {ext_addr, ~ext_addr};

  sram_cycle_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_be(req_be), .req_wdata(req_wdata), .req_beats(req_beats),
    .cfg_area(cfg_area), .cfg_setup(cfg_setup), .cfg_rd_dly(cfg_rd_dly),
    .cfg_wr_dly(cfg_wr_dly), .cfg_wait(cfg_wait), .cfg_neg_dly(cfg_neg_dly),
    .cfg_hold(cfg_hold), .cfg_bs_long(cfg_bs_long), .cfg_burst(cfg_burst),
    .cfg_pitch(cfg_pitch), .ext_rdy_n(ext_rdy_n), .ext_rdata(ext_rdata),
    .busy(busy), .done(done), .rdata(rdata), .rdata_valid(rdata_valid),
    .ext_addr(ext_addr), .ext_wdata(ext_wdata), .ext_cs_n(ext_cs_n),
    .ext_rd_n(ext_rd_n), .ext_we_n(ext_we_n), .ext_bs_n(ext_bs_n)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int strobe_len(input int w, input int k);
    int we;
    we = (w >= 26) ? 25 : w;
    if (we == 0) return 1;
    return ((k > we) ? k : we) + 1;
  endfunction

  task automatic set_cfg(input int su, input int rd, input int wr, input int wt,
                         input int ng, input int hd, input logic bs2,
                         input logic bu, input int pt);
    cfg_setup = 3'(su); cfg_rd_dly = 3'(rd); cfg_wr_dly = 3'(wr);
    cfg_wait = 5'(wt); cfg_neg_dly = 3'(ng); cfg_hold = 3'(hd);
    cfg_bs_long = bs2; cfg_burst = bu; cfg_pitch = 3'(pt);
  endtask

  // mode 0: plain, 1: configuration changed mid-cycle, 2: second request while busy
  task automatic run(input logic [31:0] a, input logic w, input logic [7:0] be,
                     input logic [63:0] wd, input logic [2:0] bm1, input int k,
                     input int mode);
    logic cs_seen;
    logic [2:0] sv_su, sv_rd, sv_wr, sv_ng, sv_hd;
    logic [4:0] sv_wt;
    m_first_cs = 0; m_first_str = 0; m_str = 0; m_cs = 0; m_bs = 0; m_bs_first = 0;
    m_rd = 0; m_done = 0; m_nv = 0; m_hold_bad = 0; m_we = '0; m_wd = '0;
    cs_seen = 1'b0;
    sv_su = cfg_setup; sv_rd = cfg_rd_dly; sv_wr = cfg_wr_dly;
    sv_wt = cfg_wait; sv_ng = cfg_neg_dly; sv_hd = cfg_hold;
    @(negedge clk);
    req_addr = a; req_write = w; req_be = be; req_wdata = wd; req_beats = bm1;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 1; i <= 300; i++) begin
      if (!ext_rd_n || ext_we_n != 8'hFF) begin
        m_str++;
        if (m_first_str == 0) m_first_str = i;
        if (ext_we_n != 8'hFF) m_wd = ext_wdata;
      end
      ext_rdy_n = (m_str > 0 && m_str <= k) ? 1'b1 : 1'b0;
      if (!ext_cs_n) begin
        m_cs++;
        cs_seen = 1'b1;
        if (m_first_cs == 0) m_first_cs = i;
      end else if (cs_seen && !cfg_burst && ext_addr != a) begin
        m_hold_bad++;
      end
      if (!ext_bs_n) begin
        m_bs++;
        if (m_bs_first == 0) m_bs_first = i;
      end
      if (!ext_rd_n) m_rd++;
      m_we = m_we | ~ext_we_n;
      if (rdata_valid && m_nv < 8) begin
        m_data[m_nv] = rdata;
        m_nv++;
      end
      if (mode == 1 && i == 2) set_cfg(7, 6, 6, 9, 5, 6, 1'b1, 1'b0, 0);
      if (mode == 2 && i == 3) begin
        req_addr = a ^ 32'h100; req_valid = 1'b1;
      end
      if (mode == 2 && i == 4) req_valid = 1'b0;
      if (done) begin
        m_done = i;
        break;
      end
      @(negedge clk);
    end
    ext_rdy_n = 1'b0;
    req_valid = 1'b0;
    if (mode == 1) begin
      cfg_setup = sv_su; cfg_rd_dly = sv_rd; cfg_wr_dly = sv_wr;
      cfg_wait = sv_wt; cfg_neg_dly = sv_ng; cfg_hold = sv_hd;
    end
  endtask

  localparam logic [31:0] A3 = 32'h0C00_0040;  // bits 28:26 = 3
  localparam logic [31:0] A4 = 32'h1000_0080;  // bits 28:26 = 4

  task automatic t_reset();
    chk("R14 cs_n after reset", 64'(ext_cs_n), 64'd1);
    chk("R14 rd_n after reset", 64'(ext_rd_n), 64'd1);
    chk("R14 we_n after reset", 64'(ext_we_n), 64'hFF);
    chk("R14 bs_n after reset", 64'(ext_bs_n), 64'd1);
    chk("R14 busy after reset", 64'(busy), 64'd0);
    chk("R8 done after reset", 64'(done), 64'd0);
  endtask

  task automatic t_read_basic();
    set_cfg(2, 1, 3, 2, 1, 2, 1'b0, 1'b0, 0);
    run(A3, 1'b0, 8'hFF, '0, 3'd0, 0, 0);
    chk("R2 first cs cycle", 64'(m_first_cs), 64'd3);
    chk("R3 read strobe start", 64'(m_first_str), 64'd4);
    chk("R4 strobe length", 64'(m_str), 64'(strobe_len(2, 0)));
    chk("R7 cs length incl negate", 64'(m_cs), 64'(1 + 3 + 1));
    chk("R8 done cycle", 64'(m_done), 64'(2 + 1 + 3 + 1 + 2 + 1));
    chk("R8 address hold", 64'(m_hold_bad), 64'd0);
    chk("R9 bs length short", 64'(m_bs), 64'd1);
    chk("R9 bs start", 64'(m_bs_first), 64'd3);
    chk("R10 no write strobe on read", 64'(m_we), 64'd0);
    chk("R10 read strobe cycles", 64'(m_rd), 64'd3);
    chk("R11 read beats", 64'(m_nv), 64'd1);
    chk("R11 read data", m_data[0], {A3, ~A3});
  endtask

  task automatic t_write();
    set_cfg(0, 5, 2, 0, 0, 0, 1'b1, 1'b0, 0);
    run(A3, 1'b1, 8'hA5, 64'h1122_3344_5566_7788, 3'd0, 0, 0);
    chk("R2 zero setup", 64'(m_first_cs), 64'd1);
    chk("R3 write delay field", 64'(m_first_str), 64'd3);
    chk("R10 write lanes", 64'(m_we), 64'hA5);
    chk("R10 write data", m_wd, 64'h1122_3344_5566_7788);
    chk("R10 no read strobe on write", 64'(m_rd), 64'd0);
    chk("R9 bs long", 64'(m_bs), 64'd2);
    chk("R8 done cycle write", 64'(m_done), 64'd4);
    chk("R11 no capture on write", 64'(m_nv), 64'd0);
  endtask

  task automatic t_bs_short();
    set_cfg(1, 0, 4, 1, 0, 0, 1'b1, 1'b0, 0);
    run(A3, 1'b0, 8'hFF, '0, 3'd0, 0, 0);
    chk("R9 bs long needs nonzero delay", 64'(m_bs), 64'd1);
    chk("R3 zero read delay", 64'(m_first_str), 64'd2);
  endtask

  task automatic t_ready();
    set_cfg(0, 0, 0, 3, 0, 0, 1'b0, 1'b0, 0);
    run(A3, 1'b0, 8'hFF, '0, 3'd0, 6, 0);
    chk("R5 ready extends", 64'(m_str), 64'(strobe_len(3, 6)));
    run(A3, 1'b0, 8'hFF, '0, 3'd0, 2, 0);
    chk("R5 ready cannot shorten", 64'(m_str), 64'(strobe_len(3, 2)));
    set_cfg(0, 0, 0, 0, 0, 0, 1'b0, 1'b0, 0);
    run(A3, 1'b1, 8'h0F, '0, 3'd0, 5, 0);
    chk("R6 ready ignored", 64'(m_str), 64'd1);
    chk("R6 done cycle", 64'(m_done), 64'd2);
  endtask

  task automatic t_clamp();
    set_cfg(0, 0, 0, 31, 0, 0, 1'b0, 1'b0, 0);
    run(A3, 1'b0, 8'hFF, '0, 3'd0, 0, 0);
    chk("R4 wait clamp 31", 64'(m_str), 64'd26);
    cfg_wait = 5'd25;
    run(A3, 1'b0, 8'hFF, '0, 3'd0, 0, 0);
    chk("R4 wait 25", 64'(m_str), 64'd26);
  endtask

  task automatic t_area();
    set_cfg(1, 1, 1, 1, 1, 1, 1'b0, 1'b0, 0);
    cfg_area = 3'd3;
    run(A4, 1'b0, 8'hFF, '0, 3'd0, 0, 0);
    chk("R1 miss no cs", 64'(m_cs), 64'd0);
    chk("R1 miss no strobe", 64'(m_str), 64'd0);
    chk("R1 miss done cycle", 64'(m_done), 64'd1);
    cfg_area = 3'd4;
    run(A4, 1'b0, 8'hFF, '0, 3'd0, 0, 0);
    chk("R1 hit cs length", 64'(m_cs), 64'd4);
    cfg_area = 3'd3;
  endtask

  task automatic t_burst();
    set_cfg(1, 1, 1, 1, 1, 0, 1'b0, 1'b1, 2);
    run(A3, 1'b0, 8'hFF, '0, 3'd3, 0, 0);
    chk("R12 burst strobe cycles", 64'(m_str), 64'(2 + 3 * 3));
    chk("R12 rd held low", 64'(m_rd), 64'(2 + 3 * 3));
    chk("R12 beats captured", 64'(m_nv), 64'd4);
    for (int b = 0; b < 4; b++) begin
      chk($sformatf("R12 beat %0d data", b), m_data[b],
          {A3 + 32'(8 * b), ~(A3 + 32'(8 * b))});
    end
    chk("R12 burst done cycle", 64'(m_done), 64'(1 + 1 + 11 + 1 + 1));
    run(A3, 1'b1, 8'hFF, '0, 3'd3, 0, 0);
    chk("R12 write single beat", 64'(m_str), 64'd2);
    cfg_burst = 1'b0;
  endtask

  task automatic t_cfg_change();
    set_cfg(1, 2, 2, 2, 2, 1, 1'b0, 1'b0, 0);
    run(A3, 1'b0, 8'hFF, '0, 3'd0, 0, 1);
    chk("R13 strobe unchanged", 64'(m_str), 64'd3);
    chk("R13 bs unchanged", 64'(m_bs), 64'd1);
    chk("R13 done unchanged", 64'(m_done), 64'(1 + 2 + 3 + 2 + 1 + 1));
  endtask

  task automatic t_busy_ignore();
    set_cfg(2, 2, 2, 2, 1, 1, 1'b0, 1'b0, 0);
    run(A3, 1'b0, 8'hFF, '0, 3'd0, 0, 2);
    chk("R14 done unaffected", 64'(m_done), 64'(2 + 2 + 3 + 1 + 1 + 1));
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R14 no second access busy", 64'(busy), 64'd0);
      chk("R14 no second access cs", 64'(ext_cs_n), 64'd1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL R14 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_basic();
    t_write();
    t_bs_short();
    t_ready();
    t_clamp();
    t_area();
    t_burst();
    t_cfg_change();
    t_busy_ignore();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule